// File: doc/BRIEF.md
# Frame Alignment Delay Meter

This block measures how far an evaluation signal lags the 8 kHz reference frame pulse. Software uses the number to program per-stream input offsets. The delay is counted in master clock cycles, which are half-bit units. The register bus decode and the use of the result are outside the block.

A measurement runs as a handshake. The start bit is first held low for a whole frame, and the measurement begins when the start bit rises. The first reference frame edge after that opens a one-frame window. In the window, the block counts cycles until the first matching edge of the evaluation signal. The reference edge after that closes the window, sets the completion flag and puts out the 12-bit result.

The edge polarity depends on the bus mode:
- In ST-BUS mode, falling edges of both signals are compared.
- In GCI mode, rising edges of both signals are compared.

When wide-frame-pulse mode is selected, the block makes no measurement.

Top module: `frame_skew_meter`

## Requirements
- R1: The block is armed only after two reference edges have been seen while start was low, which is one complete frame. A rising edge of start while the block is not armed is ignored, and done stays 0.
- R2: An armed rising edge of start begins a measurement. The first reference edge after it opens the measurement window.
- R3: done rises in the cycle of the second reference edge after the start rise, which is two frames later. result is valid from that cycle and stays unchanged while done stays high.
- R4: result is the number of clock cycles from the reference edge that opened the window to the first qualifying evaluation edge in the window. It is 0 when both edges fall in the same cycle. It saturates at 4095. Later evaluation edges in the window are ignored.
- R5: In ST-BUS mode (gci_mode=0), the reference edge is a falling edge of frame_pulse and the evaluation edge is a falling edge of eval_in.
- R6: In GCI mode (gci_mode=1), the reference edge is a rising edge of frame_pulse and the evaluation edge is a rising edge of eval_in. Edges of the opposite direction are ignored.
- R7: Driving start low clears done on the next clock edge and aborts any measurement in progress. A new measurement then needs re-arming.
- R8: If the window holds no qualifying evaluation edge, done still sets and result reads 0.
- R9: While wide_mode is 1, a start rise begins no measurement and done does not set.
- R10: After reset, done is 0 and result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_pulse | input | 1 | Reference 8 kHz frame pulse |
| eval_in | input | 1 | Evaluation signal to be measured |
| start | input | 1 | Measurement start bit |
| gci_mode | input | 1 | 0 selects ST-BUS edge polarity, 1 selects GCI polarity |
| wide_mode | input | 1 | 1 disables measurement |
| result | output | 12 | Measured delay in clock cycles |
| done | output | 1 | Measurement complete flag |

## Verification
A wrong arm count shows one frame late or early. In that case done either never rises after a short low period, or it rises when a rise should have been ignored. A cycle counter that restarts off by one, or a wrong edge polarity, shows up in result at the completion edge. A window that opens or closes on the wrong frame moves the rise of done by a whole frame. The bench samples done just before and just after that boundary, so such an error is caught within one frame.

// File: rtl/frame_skew_meter.sv
module frame_skew_meter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_pulse,
  input  logic          eval_in,
  input  logic          start,
  input  logic          gci_mode,
  input  logic          wide_mode,
  output logic [CW-1:0] result,
  output logic          done
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_MEAS, S_FIN} st_t;
  st_t st;

  logic fp_q, ev_q, start_q, opened, got;
  logic [1:0] arm;
  logic [CW-1:0] cnt, cap;

  wire ref_edge  = gci_mode ? (frame_pulse & ~fp_q) : (~frame_pulse & fp_q);
  wire eval_edge = gci_mode ? (eval_in & ~ev_q) : (~eval_in & ev_q);
  wire start_up  = start & ~start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fp_q <= 1'b0; ev_q <= 1'b0; start_q <= 1'b0;
    end else begin
      fp_q <= frame_pulse; ev_q <= eval_in; start_q <= start;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; arm <= '0; opened <= 1'b0; got <= 1'b0;
      cnt <= '0; cap <= '0; result <= '0; done <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (start) arm <= '0;
          else if (ref_edge && arm != 2'd2) arm <= arm + 2'd1;
          if (start_up && arm == 2'd2 && !wide_mode) begin
            st <= S_MEAS; opened <= 1'b0; got <= 1'b0; result <= '0;
          end
        end
        S_MEAS: begin
          if (!start || wide_mode) begin
            st <= S_IDLE; arm <= '0;
          end else if (ref_edge) begin
            if (!opened) begin
              opened <= 1'b1;
              cnt <= {{(CW-1){1'b0}}, 1'b1};
              if (eval_edge) begin got <= 1'b1; cap <= '0; end
            end else begin
              done <= 1'b1;
              result <= got ? cap : '0;
              st <= S_FIN;
            end
          end else if (opened) begin
            if (cnt != CMAX) cnt <= cnt + 1'b1;
            if (eval_edge && !got) begin got <= 1'b1; cap <= cnt; end
          end
        end
        default: begin
          if (!start) begin
            st <= S_IDLE; done <= 1'b0; arm <= '0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/frame_skew_meter_chk.sv
module frame_skew_meter_chk #(
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_pulse,
  input logic          start,
  input logic          gci_mode,
  input logic          wide_mode,
  input logic [CW-1:0] result,
  input logic          done
);
  logic fp_prev, seen;
  always_ff @(posedge clk) begin
    if (!rst_n) begin fp_prev <= 1'b0; seen <= 1'b0; end
    else begin fp_prev <= frame_pulse; seen <= 1'b1; end
  end
  wire ref_c = gci_mode ? (frame_pulse & ~fp_prev) : (~frame_pulse & fp_prev);

  AST_CLEAR_ON_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done); // R7
  AST_WIDE_BLOCKS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && !done) |=> !done); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done || $stable(result))); // R3
  AST_DONE_AT_REF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !$past(done) && done) |-> $past(ref_c)); // R3
endmodule

bind frame_skew_meter frame_skew_meter_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .start(start),
  .gci_mode(gci_mode), .wide_mode(wide_mode), .result(result), .done(done));

// File: tb/frame_skew_meter_bench.sv
module frame_skew_meter_bench;
  localparam int CLK_PER = 10;
  localparam int FLEN = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_pulse = 1'b1, eval_in = 1'b1, start = 1'b0, gci_mode = 1'b0, wide_mode = 1'b0;
  logic [11:0] result;
  logic done;
  int n_chk = 0, n_fail = 0;

  frame_skew_meter u_frame_skew_meter (
    .clk(clk), .rst_n(rst_n), .frame_pulse(frame_pulse), .eval_in(eval_in),
    .start(start), .gci_mode(gci_mode), .wide_mode(wide_mode),
    .result(result), .done(done));

  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame(input int len, input int off);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      frame_pulse = (i == 0) ? gci_mode : ~gci_mode;
      if (i == off) eval_in = gci_mode;
      else if (i == 0 || i == len - 1) eval_in = ~gci_mode;
    end
  endtask

  task automatic set_mode(input logic g);
    @(negedge clk);
    start = 1'b0; gci_mode = g;
    frame_pulse = ~g; eval_in = ~g;
  endtask

  task automatic arm_and_start();
    set_mode(gci_mode);
    frame(FLEN, -1);
    frame(FLEN, -1);
    start = 1'b1;
  endtask

  task automatic measure(input string req, input logic g, input int lena, input int off, input int exp);
    set_mode(g);
    arm_and_start();
    frame(lena, off);
    check({req, " done low after one frame"}, done, 0);
    frame(FLEN, -1);
    check({req, " done high after two frames"}, done, 1);
    check({req, " result"}, result, exp);
  endtask

  task automatic t_reset();
    check("R10 done after reset", done, 0);
    check("R10 result after reset", result, 0);
  endtask

  task automatic t_clear_and_short_arm();
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    check("R7 done clears after start low", done, 0);
    @(negedge clk); start = 1'b1;
    frame(FLEN, 5); frame(FLEN, 5); frame(FLEN, 5);
    check("R1 short low period ignored", done, 0);
  endtask

  task automatic t_wide();
    set_mode(1'b0);
    wide_mode = 1'b1;
    arm_and_start();
    frame(FLEN, 7); frame(FLEN, 7); frame(FLEN, 7);
    check("R9 wide mode no measurement", done, 0);
    wide_mode = 1'b0;
  endtask

  task automatic t_abort();
    set_mode(1'b0);
    arm_and_start();
    frame(FLEN, 9);
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1;
    frame(FLEN, 9); frame(FLEN, 9);
    check("R7 abort needs re-arming", done, 0);
  endtask

  initial begin
    #(CLK_PER * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    measure("R5 R2 R3 stbus delay 10", 1'b0, FLEN, 10, 10);
    t_clear_and_short_arm();
    measure("R6 gci delay 23", 1'b1, FLEN, 23, 23);
    measure("R4 same cycle", 1'b0, FLEN, 0, 0);
    measure("R8 no edge", 1'b1, FLEN, -1, 0);
    measure("R4 saturation", 1'b0, 5000, 4500, 4095);
    t_wide();
    t_abort();
    measure("R1 after re-arm", 1'b0, FLEN, 40, 40);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule